// File: doc/BRIEF.md
# Test-Port Instruction Register and Data-Path Selector

This block sits behind an IEEE 1149.1 test access port state machine. It holds a 3-bit instruction register, which has a shift stage and a separate parallel (active) instruction. It decodes the active instruction into a choice of test data register and a set of flags that control the pins. It contains a 1-bit bypass register and a 32-bit identification register. The boundary register is outside the block and reaches it only through its serial output. The block also produces the serial test output and that output's enable.

The state machine supplies one strobe per state: test-logic-reset, capture-IR, shift-IR, update-IR, capture-DR and shift-DR. A strobe is high for the whole TCK period in which the controller is in that state. The shift and capture actions take place on the rising TCK edge that ends such a period. The instruction latch and the serial output act on the falling edge in the middle of the period. The port is a bit-serial scan path paced only by TCK, so it has no valid/ready handshake and no back-pressure. The test-logic-reset strobe is the block's only reset.

Top module: `tap_instr_unit`

## Requirements
- R1: While shift-IR is high, each rising TCK moves the instruction shift stage one place toward bit 0, and `tdi` enters bit 2. Bit 0 is the stage's serial output.
- R2: On a rising TCK with capture-IR high, the shift stage loads 3'b001. The first two bits shifted out afterwards are therefore 1 and then 0.
- R3: On a falling TCK with update-IR high, the shift stage is copied to `instr`. `instr` holds its value at every other edge.
- R4: On a falling TCK with test-logic-reset high, `instr` becomes IDCODE (3'b110). On a rising TCK with test-logic-reset high, the shift stage becomes 3'b001. Test-logic-reset takes priority over every other strobe.
- R5: The path selectors are one-hot. `sel_bsr` is high for 3'b000 (external test) and 3'b100 (sample/preload). `sel_id` is high for 3'b110. `sel_byp` is high for 3'b010, 3'b011 and 3'b111, and also for the unused codes 3'b001 and 3'b101.
- R6: `drv_bsr` is high for 3'b000 and for 3'b011 (clamp). `out_hiz` is high only for 3'b010. `out_hold` is high only for 3'b011.
- R7: When bypass is selected, the bypass bit loads 0 on a rising TCK in capture-DR. In shift-DR it loads `tdi`, so data passes through with one bit of delay.
- R8: When IDCODE is selected, the identification register loads {VERSION[3:0], PART[15:0], MAKER[10:0], 1'b1} on a rising TCK in capture-DR. In shift-DR it shifts out LSB first, with `tdi` entering bit 31.
- R9: On each falling TCK, `tdo_oe` takes the value (shift-IR or shift-DR). In shift-IR, `tdo` takes bit 0 of the shift stage. In shift-DR, `tdo` takes the selected register's bit 0, which for the boundary path is `bsr_so`. Otherwise `tdo` takes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tdi | input | 1 | Serial test data in |
| st_tlr | input | 1 | Controller in test-logic-reset |
| st_cap_ir | input | 1 | Controller in capture-IR |
| st_sh_ir | input | 1 | Controller in shift-IR |
| st_upd_ir | input | 1 | Controller in update-IR |
| st_cap_dr | input | 1 | Controller in capture-DR |
| st_sh_dr | input | 1 | Controller in shift-DR |
| bsr_so | input | 1 | Serial output of the external boundary register |
| instr | output | 3 | Active (parallel) instruction |
| sel_bsr | output | 1 | Boundary register is the selected path |
| sel_byp | output | 1 | Bypass bit is the selected path |
| sel_id | output | 1 | Identification register is the selected path |
| drv_bsr | output | 1 | Pins driven from boundary register outputs |
| out_hiz | output | 1 | All pins forced to high impedance |
| out_hold | output | 1 | Boundary output stage must not update |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for `tdo` |

## Verification
Every opcode, including the two unused codes, is loaded through a full IR scan. This separates decode errors in the selectors from decode errors in the pin flags. It also exposes the 001 capture pattern on `tdo`. After each load, a DR scan with a changing `tdi` and `bsr_so` pattern shows which path reaches `tdo`. That scan also shows whether a bypass path adds exactly one bit of delay and whether the boundary path passes through with none. A long scan after reset sends out the full identification word and then the `tdi` bits behind it, which checks bit order and the field layout. A reset given in the middle of an IR scan, followed by idle periods with no update strobe, shows that IDCODE is forced and that the instruction otherwise stays put.

// File: rtl/tap_instr_pkg.sv
package tap_instr_pkg;
  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_CLAMP  = 3'b011;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b110;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef struct packed {
    logic bsr;
    logic byp;
    logic id;
  } path_sel_t;

  typedef struct packed {
    logic drive;
    logic hiz;
    logic hold;
  } pin_ctl_t;
endpackage

// File: rtl/tap_ir_stage.sv
module tap_ir_stage
  import tap_instr_pkg::*;
#(
  parameter logic [IR_W-1:0] CAP_PAT = IR_CAPTURE,
  parameter logic [IR_W-1:0] RST_OP  = OP_IDCODE
) (
  input  logic            tck,
  input  logic            tdi,
  input  logic            st_tlr,
  input  logic            st_cap,
  input  logic            st_sh,
  input  logic            st_upd,
  output logic            sh_lsb,
  output logic [IR_W-1:0] instr
);
  logic [IR_W-1:0] sh_q;

  // Shift stage acts on the rising edge.
  always_ff @(posedge tck) begin
    if (st_tlr)      sh_q <= CAP_PAT;
    else if (st_cap) sh_q <= CAP_PAT;
    else if (st_sh)  sh_q <= {tdi, sh_q[IR_W-1:1]};
  end

  // Parallel instruction acts on the falling edge.
  always_ff @(negedge tck) begin
    if (st_tlr)      instr <= RST_OP;
    else if (st_upd) instr <= sh_q;
  end

  assign sh_lsb = sh_q[0];

  // R1
  ir_shift_chk: assert property (@(posedge tck) disable iff (st_tlr)
    (st_sh && !st_cap) |=> sh_q == {$past(tdi), $past(sh_q[IR_W-1:1])});
  // R2
  ir_capture_chk: assert property (@(posedge tck) disable iff (st_tlr)
    st_cap |=> sh_q[1:0] == 2'b01);
  // R3
  ir_update_chk: assert property (@(negedge tck) disable iff (st_tlr)
    st_upd |=> instr == $past(sh_q));
  // R4
  ir_reset_chk: assert property (@(negedge tck)
    st_tlr |=> instr == RST_OP);
endmodule

// File: rtl/tap_ir_decode.sv
module tap_ir_decode
  import tap_instr_pkg::*;
(
  input  logic [IR_W-1:0] instr,
  output path_sel_t       sel,
  output pin_ctl_t        pins
);
  always_comb begin
    sel  = '0;
    pins = '0;
    case (instr)
      OP_EXTEST: begin sel.bsr = 1'b1; pins.drive = 1'b1; end
      OP_SAMPLE: sel.bsr = 1'b1;
      OP_IDCODE: sel.id = 1'b1;
      OP_HIGHZ:  begin sel.byp = 1'b1; pins.hiz = 1'b1; end
      OP_CLAMP:  begin sel.byp = 1'b1; pins.drive = 1'b1; pins.hold = 1'b1; end
      default:   sel.byp = 1'b1;
    endcase
  end
endmodule

// File: rtl/tap_data_regs.sv
module tap_data_regs #(
  parameter logic [10:0] MAKER   = 11'h0A5,
  parameter logic [15:0] PART    = 16'h1C3B,
  parameter logic [3:0]  VERSION = 4'h2
) (
  input  logic tck,
  input  logic tdi,
  input  logic st_tlr,
  input  logic st_cap_dr,
  input  logic st_sh_dr,
  input  logic sel_byp,
  input  logic sel_id,
  output logic byp_so,
  output logic id_so
);
  localparam int ID_W = 1 + $bits(MAKER) + $bits(PART) + $bits(VERSION);
  localparam logic [ID_W-1:0] ID_VAL = {VERSION, PART, MAKER, 1'b1};

  logic            byp_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck) begin
    if (sel_byp) begin
      if (st_cap_dr)     byp_q <= 1'b0;
      else if (st_sh_dr) byp_q <= tdi;
    end
  end

  always_ff @(posedge tck) begin
    if (sel_id) begin
      if (st_cap_dr)     id_q <= ID_VAL;
      else if (st_sh_dr) id_q <= {tdi, id_q[ID_W-1:1]};
    end
  end

  assign byp_so = byp_q;
  assign id_so  = id_q[0];

  // R7
  byp_capture_chk: assert property (@(posedge tck) disable iff (st_tlr)
    (sel_byp && st_cap_dr) |=> !byp_q);
  // R8
  id_capture_chk: assert property (@(posedge tck) disable iff (st_tlr)
    (sel_id && st_cap_dr) |=> id_q == ID_VAL);
  // R8
  id_shift_chk: assert property (@(posedge tck) disable iff (st_tlr)
    (sel_id && st_sh_dr && !st_cap_dr) |=> id_q[ID_W-1] == $past(tdi));
endmodule

// File: rtl/tap_instr_unit.sv
module tap_instr_unit
  import tap_instr_pkg::*;
#(
  parameter logic [10:0] MAKER   = 11'h0A5,
  parameter logic [15:0] PART    = 16'h1C3B,
  parameter logic [3:0]  VERSION = 4'h2
) (
  input  logic        tck,
  input  logic        tdi,
  input  logic        st_tlr,
  input  logic        st_cap_ir,
  input  logic        st_sh_ir,
  input  logic        st_upd_ir,
  input  logic        st_cap_dr,
  input  logic        st_sh_dr,
  input  logic        bsr_so,
  output logic [2:0]  instr,
  output logic        sel_bsr,
  output logic        sel_byp,
  output logic        sel_id,
  output logic        drv_bsr,
  output logic        out_hiz,
  output logic        out_hold,
  output logic        tdo,
  output logic        tdo_oe
);
  logic      ir_lsb;
  logic      byp_so;
  logic      id_so;
  logic      dr_bit;
  path_sel_t sel;
  pin_ctl_t  pins;

  tap_ir_stage u_ir (
    .tck    (tck),
    .tdi    (tdi),
    .st_tlr (st_tlr),
    .st_cap (st_cap_ir),
    .st_sh  (st_sh_ir),
    .st_upd (st_upd_ir),
    .sh_lsb (ir_lsb),
    .instr  (instr)
  );

  tap_ir_decode u_dec (
    .instr (instr),
    .sel   (sel),
    .pins  (pins)
  );

  tap_data_regs #(
    .MAKER   (MAKER),
    .PART    (PART),
    .VERSION (VERSION)
  ) u_dr (
    .tck       (tck),
    .tdi       (tdi),
    .st_tlr    (st_tlr),
    .st_cap_dr (st_cap_dr),
    .st_sh_dr  (st_sh_dr),
    .sel_byp   (sel.byp),
    .sel_id    (sel.id),
    .byp_so    (byp_so),
    .id_so     (id_so)
  );

  always_comb begin
    if (sel.bsr)     dr_bit = bsr_so;
    else if (sel.id) dr_bit = id_so;
    else             dr_bit = byp_so;
  end

  always_ff @(negedge tck) begin
    tdo_oe <= st_sh_ir | st_sh_dr;
    if (st_sh_ir)      tdo <= ir_lsb;
    else if (st_sh_dr) tdo <= dr_bit;
    else               tdo <= 1'b0;
  end

  assign sel_bsr  = sel.bsr;
  assign sel_byp  = sel.byp;
  assign sel_id   = sel.id;
  assign drv_bsr  = pins.drive;
  assign out_hiz  = pins.hiz;
  assign out_hold = pins.hold;

  // R5
  path_onehot_chk: assert property (@(posedge tck) disable iff (st_tlr)
    $countones({sel_bsr, sel_byp, sel_id}) == 1);
  // R6
  hold_drive_chk: assert property (@(posedge tck) disable iff (st_tlr)
    out_hold |-> (drv_bsr && !out_hiz && sel_byp));
  // R9
  oe_follow_chk: assert property (@(negedge tck)
    (st_sh_ir || st_sh_dr) |=> tdo_oe);
  // R9
  bsr_pass_chk: assert property (@(negedge tck) disable iff (st_tlr)
    (st_sh_dr && !st_sh_ir && sel_bsr) |=> tdo == $past(bsr_so));
endmodule

// File: tb/tap_instr_unit_test.sv
`timescale 1ns/1ps
module tap_instr_unit_test;
  localparam logic [31:0] ID_EXP = {4'h2, 16'h1C3B, 11'h0A5, 1'b1};
  localparam int T_TLR = 0, T_CIR = 1, T_SIR = 2, T_UIR = 3, T_CDR = 4, T_SDR = 5;

  logic tck = 1'b0;
  logic tdi = 1'b0, bsr_so = 1'b0;
  logic st_tlr = 1'b1, st_cap_ir = 1'b0, st_sh_ir = 1'b0, st_upd_ir = 1'b0;
  logic st_cap_dr = 1'b0, st_sh_dr = 1'b0;
  logic [2:0] instr;
  logic sel_bsr, sel_byp, sel_id, drv_bsr, out_hiz, out_hold, tdo, tdo_oe;

  int checks = 0, fails = 0;

  // reference state
  int m_sh = 1, m_instr = 6, m_tdo = 0, m_oe = 0;
  bit m_byp = 1'b0;
  bit id_q[$];

  always #10 tck = ~tck;

  tap_instr_unit uut (
    .tck(tck), .tdi(tdi), .st_tlr(st_tlr), .st_cap_ir(st_cap_ir),
    .st_sh_ir(st_sh_ir), .st_upd_ir(st_upd_ir), .st_cap_dr(st_cap_dr),
    .st_sh_dr(st_sh_dr), .bsr_so(bsr_so), .instr(instr), .sel_bsr(sel_bsr),
    .sel_byp(sel_byp), .sel_id(sel_id), .drv_bsr(drv_bsr), .out_hiz(out_hiz),
    .out_hold(out_hold), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // path: 0 boundary, 1 bypass, 2 id
  function automatic int path_of(input int op);
    case (op)
      0, 4: return 0;
      6: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic tick(input int st, input bit d, input bit b);
    int p;
    st_tlr = st[T_TLR]; st_cap_ir = st[T_CIR]; st_sh_ir = st[T_SIR];
    st_upd_ir = st[T_UIR]; st_cap_dr = st[T_CDR]; st_sh_dr = st[T_SDR];
    tdi = d; bsr_so = b;
    @(negedge tck); #1;
    p = path_of(m_instr);
    if (st[T_TLR]) m_instr = 6;
    else if (st[T_UIR]) m_instr = m_sh;
    m_oe = (st[T_SIR] || st[T_SDR]) ? 1 : 0;
    if (st[T_SIR]) m_tdo = m_sh & 1;
    else if (st[T_SDR]) m_tdo = (p == 0) ? int'(b) : (p == 2) ? int'(id_q[0]) : int'(m_byp);
    else m_tdo = 0;
    #4;
    p = path_of(m_instr);
    check("R3/R4 instr", int'(instr), m_instr);
    check("R5 sel_bsr", int'(sel_bsr), int'(p == 0));
    check("R5 sel_byp", int'(sel_byp), int'(p == 1));
    check("R5 sel_id", int'(sel_id), int'(p == 2));
    check("R6 drv_bsr", int'(drv_bsr), int'(m_instr == 0 || m_instr == 3));
    check("R6 out_hiz", int'(out_hiz), int'(m_instr == 2));
    check("R6 out_hold", int'(out_hold), int'(m_instr == 3));
    check("R9 tdo_oe", int'(tdo_oe), m_oe);
    check("R1/R7/R8/R9 tdo", int'(tdo), m_tdo);
    @(posedge tck); #1;
    if (st[T_TLR] || st[T_CIR]) m_sh = 1;
    else if (st[T_SIR]) m_sh = (int'(d) << 2) | (m_sh >> 1);
    if (p == 1) begin
      if (st[T_CDR]) m_byp = 1'b0;
      else if (st[T_SDR]) m_byp = d;
    end
    if (p == 2) begin
      if (st[T_CDR]) begin
        id_q.delete();
        for (int i = 0; i < 32; i++) id_q.push_back(ID_EXP[i]);
      end else if (st[T_SDR]) id_q = {id_q[1:$], d};
    end
    #1;
  endtask

  task automatic load_ir(input int op);
    tick(1 << T_CIR, 0, 0);                       // R2 pattern 001
    for (int i = 0; i < 3; i++) tick(1 << T_SIR, op[i], 0);  // R1
    tick(0, 0, 0);                                // exit
    tick(1 << T_UIR, 0, 0);                       // R3
  endtask

  task automatic dr_scan(input int n, input int seed);
    tick(1 << T_CDR, 0, 0);
    for (int i = 0; i < n; i++)
      tick(1 << T_SDR, bit'((seed >> (i % 16)) & 1), bit'((seed >> ((i + 5) % 16)) & 1));
    tick(0, 0, 0);
  endtask

  initial begin
    int ops[8] = '{0, 2, 3, 4, 7, 1, 5, 6};
    @(posedge tck); #2;
    for (int i = 0; i < 4; i++) tick(1 << T_TLR, 0, 0);   // R4 reset state
    tick(0, 0, 0);
    dr_scan(40, 16'hB3C5);                                  // R8 full ID then tdi
    foreach (ops[k]) begin
      load_ir(ops[k]);                                      // R5 R6
      dr_scan(10, 16'h5A96 ^ (k * 16'h1111));               // R7 R9
    end
    load_ir(3);
    for (int i = 0; i < 3; i++) tick(0, 1, 1);              // R3 hold with no update
    tick(1 << T_CIR, 0, 0);
    tick(1 << T_SIR, 1, 0);
    tick(1 << T_TLR, 1, 0);                                 // R4 mid-scan reset
    tick(0, 0, 0);
    tick(1 << T_CIR, 0, 0);
    for (int i = 0; i < 3; i++) tick(1 << T_SIR, 1, 0);
    tick(1 << T_UIR, 0, 0);
    dr_scan(6, 16'h00F3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tck);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule